// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block runs a single conversion on a general-purpose ADC. The ADC sits behind a register port that uses a request/acknowledge handshake. A client raises a request and gives a channel number. The sequencer then works through the converter's power-up order on its own, with every wait counted in clock cycles derived from the clock frequency. It returns a 10-bit sample together with a status code. The serial transport behind the register port, the analog converter and any calibration arithmetic all lie outside this block.

The converter is controlled through one control byte at address 0x50. Every change to that byte is a read-modify-write. The sequencer reads the byte once at the start of a request and keeps an image of it. Each later write alters only the field that step owns, so bits owned by other logic pass through unchanged. The battery-thermistor channel (channel 2) needs an external bias to be powered well before the converter is enabled; the sequencer adds that step for channel 2 only. Every way out of a request ends with a teardown write that powers the converter down. This holds for success, timeout and bus error alike.

The four channels are: 0 battery voltage, 1 die temperature, 2 battery thermistor, 3 system thermistor.

Top module: `adc_seq`

## Requirements
- R1: A request (`req_i` high) is accepted only while `busy_o` is low. `busy_o` stays high from acceptance until teardown ends, and requests raised while it is high are ignored. After reset, `busy_o`, `done_o` and `bus_req_o` are low.
- R2: The first access of every request reads the control byte at 0x50. Every later write to 0x50 keeps all bits from that read except the ones the current step changes.
- R3: The control byte has start at bit 0, channel select at bits 2:1, enable at bit 5 and thermistor bias at bit 6. The writes come in this order: enable set (start clear), then channel select, then start set. No write sets start unless enable was already set by an earlier write.
- R4: At least GAP_US microseconds of clock cycles pass between the enable write transfer and the start write transfer.
- R5: For channel 2 only, a write that sets bias comes before the enable write, at least BIAS_US microseconds earlier, and the teardown write clears bias. Other channels never change bias.
- R6: The done-interrupt flag is held clear while the start write is pending. An interrupt that arrives before start therefore cannot end the conversion.
- R7: If no interrupt arrives within TIMEOUT_US after start, the request ends with status 01. No result registers are read.
- R8: After the interrupt, the sequencer reads address 0x54+2n and then 0x55+2n. The sample is {first byte bits 1:0, second byte}, and the status is 00.
- R9: A bus error on any access sends the sequence to teardown and ends the request with status 10.
- R10: Every request ends with a teardown write that clears start and enable. `done_o` then pulses for exactly one cycle, with `status_o` and `sample_o` held.
- R11: Once `bus_req_o` is raised, it stays high with `bus_we_o`, `bus_addr_o` and `bus_wdata_o` unchanged until `bus_ack_i` or `bus_err_i` completes the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Conversion request |
| req_ch_i | input | CH_W | Channel number of the request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sample_o | output | SAMPLE_W | Last converted sample |
| status_o | output | 2 | 00 ok, 01 timeout, 10 bus error |
| irq_i | input | 1 | Conversion-done interrupt |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 write, 0 read |
| bus_addr_o | output | ADDR_W | Register address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_ack_i | input | 1 | Access completed |
| bus_err_i | input | 1 | Access failed |
| bus_rdata_i | input | DATA_W | Read data, valid with ack |

## Verification
The bench runs conversions on channels 0, 2 and 3 with control bytes that already carry foreign bits, and uses zero and two cycles of bus latency. This separates correct read-modify-write and field placement from writes that overwrite the byte, and it also exposes addressing and byte-order faults in the result read. Channel 2 is the only pattern that exposes a missing or too-short bias lead. A silent interrupt line, and an interrupt pulsed during the enable gap, both show up as timeouts; the second of these separates a flag that is cleared before start from a flag that is not. Bus errors injected on the first access and on the result read check that teardown still runs and that the error code differs from the timeout code.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RD_CTL, S_BIAS_WR, S_BIAS_WAIT, S_EN_WR, S_CH_WR,
    S_GAP_WAIT, S_START_WR, S_WAIT_DONE, S_RD_HI, S_RD_LO, S_TEAR_WR
  } seq_state_e;

  localparam logic [1:0] ST_OK      = 2'b00;
  localparam logic [1:0] ST_TIMEOUT = 2'b01;
  localparam logic [1:0] ST_BUS_ERR = 2'b10;

  localparam int unsigned CTL_ADDR     = 32'h50;
  localparam int unsigned DATA_BASE    = 32'h54;
  localparam int unsigned START_BIT    = 0;
  localparam int unsigned CH_LSB       = 1;
  localparam int unsigned EN_BIT       = 5;
  localparam int unsigned BIAS_BIT     = 6;
  localparam int unsigned BIAS_CH      = 2;

  function automatic longint unsigned us2cyc(longint unsigned hz, longint unsigned us);
    return (hz * us + 64'd999_999) / 64'd1_000_000;
  endfunction
endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/adc_seq_irq_flag.sv
module adc_seq_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_i,
  input  logic clr_i,
  output logic flag_o
);
  // clear wins: an edge landing while start is pending is stale
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (clr_i)  flag_o <= 1'b0;
    else if (irq_i)  flag_o <= 1'b1;
  end
endmodule

// File: rtl/adc_seq_ctl_img.sv
module adc_seq_ctl_img #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] val_i,
  output logic [DATA_W-1:0] img_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      img_o <= '0;
    else if (load_i)  img_o <= val_i;
  end
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 19_200_000,
  parameter int unsigned GAP_US     = 50,
  parameter int unsigned BIAS_US    = 35_000,
  parameter int unsigned TIMEOUT_US = 5_000_000,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SAMPLE_W   = 10,
  parameter int unsigned CH_W       = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [CH_W-1:0]     req_ch_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic [1:0]          status_o,
  input  logic                irq_i,
  output logic                bus_req_o,
  output logic                bus_we_o,
  output logic [ADDR_W-1:0]   bus_addr_o,
  output logic [DATA_W-1:0]   bus_wdata_o,
  input  logic                bus_ack_i,
  input  logic                bus_err_i,
  input  logic [DATA_W-1:0]   bus_rdata_i
);
  localparam longint unsigned GAP_CYC  = us2cyc(CLK_HZ, GAP_US);
  localparam longint unsigned BIAS_CYC = us2cyc(CLK_HZ, BIAS_US);
  localparam longint unsigned TO_CYC   = us2cyc(CLK_HZ, TIMEOUT_US);
  localparam longint unsigned MAX_A    = (GAP_CYC > BIAS_CYC) ? GAP_CYC : BIAS_CYC;
  localparam longint unsigned MAX_CYC  = (MAX_A > TO_CYC) ? MAX_A : TO_CYC;
  localparam int unsigned     CNT_W    = $clog2(MAX_CYC + 1);
  localparam int unsigned     HI_W     = SAMPLE_W - DATA_W;

  localparam logic [DATA_W-1:0] M_START = DATA_W'(1) << START_BIT;
  localparam logic [DATA_W-1:0] M_EN    = DATA_W'(1) << EN_BIT;
  localparam logic [DATA_W-1:0] M_BIAS  = DATA_W'(1) << BIAS_BIT;
  localparam logic [DATA_W-1:0] M_CH    = DATA_W'((1 << CH_W) - 1) << CH_LSB;

  seq_state_e        state_q;
  logic [CH_W-1:0]   ch_q;
  logic [HI_W-1:0]   hi_q;
  logic [DATA_W-1:0] img;
  logic              xfer, berr, is_ch2;
  logic              tmr_load, tmr_exp, irq_flag;
  logic [CNT_W-1:0]  tmr_val;
  logic              img_load;
  logic [DATA_W-1:0] img_val;

  assign is_ch2 = (ch_q == CH_W'(BIAS_CH));

  always_comb begin
    bus_req_o   = 1'b1;
    bus_we_o    = 1'b1;
    bus_addr_o  = ADDR_W'(CTL_ADDR);
    bus_wdata_o = img;
    unique case (state_q)
      S_RD_CTL:   bus_we_o = 1'b0;
      S_BIAS_WR:  bus_wdata_o = img | M_BIAS;
      S_EN_WR:    bus_wdata_o = (img & ~M_START) | M_EN;
      S_CH_WR:    bus_wdata_o = (img & ~M_CH) | (DATA_W'(ch_q) << CH_LSB);
      S_START_WR: bus_wdata_o = img | M_START;
      S_TEAR_WR:  bus_wdata_o = img & ~(M_START | M_EN | (is_ch2 ? M_BIAS : '0));
      S_RD_HI: begin
        bus_we_o   = 1'b0;
        bus_addr_o = ADDR_W'(DATA_BASE) + (ADDR_W'(ch_q) << 1);
      end
      S_RD_LO: begin
        bus_we_o   = 1'b0;
        bus_addr_o = ADDR_W'(DATA_BASE) + (ADDR_W'(ch_q) << 1) + ADDR_W'(1);
      end
      default: begin
        bus_req_o = 1'b0;
        bus_we_o  = 1'b0;
      end
    endcase
  end

  assign xfer = bus_req_o & bus_ack_i & ~bus_err_i;
  assign berr = bus_req_o & bus_err_i;

  assign img_load = xfer & (state_q == S_RD_CTL || (bus_we_o && state_q != S_RD_HI));
  assign img_val  = (state_q == S_RD_CTL) ? bus_rdata_i : bus_wdata_o;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (xfer) begin
      unique case (state_q)
        S_BIAS_WR:  begin tmr_load = 1'b1; tmr_val = CNT_W'(BIAS_CYC); end
        S_EN_WR:    begin tmr_load = 1'b1; tmr_val = CNT_W'(GAP_CYC);  end
        S_START_WR: begin tmr_load = 1'b1; tmr_val = CNT_W'(TO_CYC);   end
        default: ;
      endcase
    end
  end

  adc_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .expired_o(tmr_exp)
  );

  adc_seq_irq_flag u_irq (
    .clk_i, .rst_ni, .irq_i, .clr_i(state_q == S_START_WR), .flag_o(irq_flag)
  );

  adc_seq_ctl_img #(.DATA_W(DATA_W)) u_img (
    .clk_i, .rst_ni, .load_i(img_load), .val_i(img_val), .img_o(img)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      ch_q     <= '0;
      hi_q     <= '0;
      sample_o <= '0;
      status_o <= ST_OK;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (berr) begin
        status_o <= ST_BUS_ERR;
        if (state_q == S_TEAR_WR) begin
          state_q <= S_IDLE;
          done_o  <= 1'b1;
        end else begin
          state_q <= S_TEAR_WR;
        end
      end else begin
        unique case (state_q)
          S_IDLE: if (req_i) begin
            ch_q     <= req_ch_i;
            status_o <= ST_OK;
            state_q  <= S_RD_CTL;
          end
          S_RD_CTL:    if (xfer) state_q <= is_ch2 ? S_BIAS_WR : S_EN_WR;
          S_BIAS_WR:   if (xfer) state_q <= S_BIAS_WAIT;
          S_BIAS_WAIT: if (tmr_exp) state_q <= S_EN_WR;
          S_EN_WR:     if (xfer) state_q <= S_CH_WR;
          S_CH_WR:     if (xfer) state_q <= S_GAP_WAIT;
          S_GAP_WAIT:  if (tmr_exp) state_q <= S_START_WR;
          S_START_WR:  if (xfer) state_q <= S_WAIT_DONE;
          S_WAIT_DONE: begin
            if (irq_flag) state_q <= S_RD_HI;
            else if (tmr_exp) begin
              status_o <= ST_TIMEOUT;
              state_q  <= S_TEAR_WR;
            end
          end
          S_RD_HI: if (xfer) begin
            hi_q    <= bus_rdata_i[HI_W-1:0];
            state_q <= S_RD_LO;
          end
          S_RD_LO: if (xfer) begin
            sample_o <= {hi_q, bus_rdata_i};
            state_q  <= S_TEAR_WR;
          end
          S_TEAR_WR: if (xfer) begin
            state_q <= S_IDLE;
            done_o  <= 1'b1;
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (state_q != S_IDLE);

  // cycles since the last bias or enable write; used only by the checks below
  logic [CNT_W-1:0] mark_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mark_cnt <= '0;
    else if (xfer && (state_q == S_BIAS_WR || state_q == S_EN_WR)) mark_cnt <= '0;
    else if (mark_cnt != '1) mark_cnt <= mark_cnt + 1'b1;
  end

  p_accept_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i));
  p_start_after_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o && bus_wdata_o[START_BIT]) |-> img[EN_BIT]);
  p_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer && state_q == S_START_WR) |-> (mark_cnt >= CNT_W'(GAP_CYC)));
  p_bias_lead_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer && state_q == S_EN_WR && is_ch2) |-> (mark_cnt >= CNT_W'(BIAS_CYC)));
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_teardown_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o != ST_BUS_ERR) |-> (!img[EN_BIT] && !img[START_BIT]));
  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i && !bus_err_i) |=>
      (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_wdata_o)));
endmodule

// File: tb/adc_seq_bench.sv
module adc_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int GAP_C  = 50;
  localparam int BIAS_C = 200;
  localparam int TO_C   = 1000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic [1:0] req_ch_i = '0;
  logic       busy_o, done_o;
  logic [9:0] sample_o;
  logic [1:0] status_o;
  logic       irq_i = 1'b0;
  logic       bus_req_o, bus_we_o;
  logic [7:0] bus_addr_o, bus_wdata_o;
  logic       bus_ack_i = 1'b0, bus_err_i = 1'b0;
  logic [7:0] bus_rdata_i = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq #(.CLK_HZ(1_000_000), .GAP_US(GAP_C), .BIAS_US(BIAS_C), .TIMEOUT_US(TO_C)) u_adc_seq (
    .clk_i(clk), .rst_ni, .req_i, .req_ch_i, .busy_o, .done_o, .sample_o, .status_o,
    .irq_i, .bus_req_o, .bus_we_o, .bus_addr_o, .bus_wdata_o,
    .bus_ack_i, .bus_err_i, .bus_rdata_i
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // slave model state
  logic [7:0] ctl_model;
  logic [7:0] mem [0:7];
  int lat = 0, wait_cnt = 0, acc_idx = 0, err_at = -1;
  int irq_delay = -1, irq_cnt = -1;
  bit stale_mode = 0, stale_pend = 0;
  logic [7:0] cap_addr, cap_data; logic cap_we;
  logic [7:0] wr_data [0:15]; int wr_cyc [0:15]; int n_wr = 0;
  logic [7:0] rd_addr [0:15]; int n_rd = 0;
  int hold_bad = 0;
  logic [7:0] prev_addr; logic prev_pending = 0;

  always @(negedge clk) begin
    irq_i = 1'b0;
    if (stale_pend) begin irq_i = 1'b1; stale_pend = 0; end
    if (irq_cnt >= 0) begin
      if (irq_cnt == 0) irq_i = 1'b1;
      irq_cnt = irq_cnt - 1;
    end
    if (prev_pending && (!bus_req_o || bus_addr_o != prev_addr)) hold_bad++;
    prev_pending = 0;
    if (bus_ack_i || bus_err_i) begin
      if (bus_ack_i && cap_we && cap_addr == 8'h50) begin
        if (!ctl_model[0] && cap_data[0] && irq_delay >= 0) irq_cnt = irq_delay;
        if (stale_mode && !cap_data[0]) stale_pend = 1;
        ctl_model = cap_data;
        if (n_wr < 16) begin wr_data[n_wr] = cap_data; wr_cyc[n_wr] = cyc; end
        n_wr++;
      end else if (bus_ack_i && !cap_we) begin
        if (n_rd < 16) rd_addr[n_rd] = cap_addr;
        n_rd++;
      end
      acc_idx++;
      bus_ack_i = 0; bus_err_i = 0; wait_cnt = 0;
    end else if (bus_req_o) begin
      if (wait_cnt >= lat) begin
        cap_addr = bus_addr_o; cap_data = bus_wdata_o; cap_we = bus_we_o;
        if (acc_idx == err_at) bus_err_i = 1;
        else begin
          bus_ack_i = 1;
          if (bus_addr_o == 8'h50) bus_rdata_i = ctl_model;
          else if (bus_addr_o >= 8'h54 && bus_addr_o <= 8'h5B) bus_rdata_i = mem[bus_addr_o - 8'h54];
          else bus_rdata_i = 8'h00;
        end
      end else begin
        wait_cnt++;
        prev_pending = 1; prev_addr = bus_addr_o;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  logic [9:0] got_sample; logic [1:0] got_status;

  task automatic run(input logic [1:0] ch, input int l, input int idly, input int eat,
                     input bit stale, input bit poke);
    int n;
    lat = l; irq_delay = idly; err_at = eat; stale_mode = stale;
    acc_idx = 0; n_wr = 0; n_rd = 0; ctl_model = 8'h98;
    @(negedge clk);
    req_i = 1; req_ch_i = ch;
    @(negedge clk);
    req_i = 0;
    if (poke) begin
      repeat (5) @(negedge clk);
      req_i = 1; req_ch_i = 2'd3;
      @(negedge clk);
      req_i = 0;
    end
    n = 0;
    while (!done_o && n < 5000) begin @(negedge clk); n++; end
    chk(done_o == 1'b1, "R10 done reached", done_o, 1);
    got_sample = sample_o; got_status = status_o;
    @(negedge clk);
    chk(done_o == 1'b0, "R10 done single cycle", done_o, 0);
    chk(status_o == got_status, "R10 status held", status_o, got_status);
    stale_mode = 0; irq_cnt = -1;
  endtask

  task automatic t_reset();
    chk(busy_o == 0, "R1 reset busy", busy_o, 0);
    chk(done_o == 0, "R1 reset done", done_o, 0);
    chk(bus_req_o == 0, "R1 reset bus_req", bus_req_o, 0);
  endtask

  task automatic t_ch0();
    mem[0] = 8'hFE; mem[1] = 8'h5A;
    run(2'd0, 0, 3, -1, 0, 0);
    chk(got_status == 2'b00, "R8 ch0 status", got_status, 0);
    chk(got_sample == 10'h25A, "R8 ch0 sample", got_sample, 10'h25A);
    chk(n_rd == 3 && rd_addr[0] == 8'h50, "R2 ctl read first", rd_addr[0], 8'h50);
    chk(rd_addr[1] == 8'h54 && rd_addr[2] == 8'h55, "R8 ch0 addr order", rd_addr[1], 8'h54);
    chk(n_wr == 4, "R3 ch0 write count", n_wr, 4);
    chk(wr_data[0] == 8'hB8, "R3 enable write", wr_data[0], 8'hB8);
    chk(wr_data[1] == 8'hB8, "R3 channel write", wr_data[1], 8'hB8);
    chk(wr_data[2] == 8'hB9, "R3 start write", wr_data[2], 8'hB9);
    chk(wr_data[3] == 8'h98, "R10 R2 teardown keeps foreign bits", wr_data[3], 8'h98);
    chk(wr_cyc[2] - wr_cyc[0] >= GAP_C, "R4 enable-start gap", wr_cyc[2] - wr_cyc[0], GAP_C);
  endtask

  task automatic t_ch3_lat();
    mem[6] = 8'h01; mem[7] = 8'hC3;
    run(2'd3, 2, 10, -1, 0, 0);
    chk(got_sample == 10'h1C3, "R8 ch3 sample", got_sample, 10'h1C3);
    chk(rd_addr[1] == 8'h5A && rd_addr[2] == 8'h5B, "R8 ch3 addr", rd_addr[1], 8'h5A);
    chk(wr_data[1] == 8'hBE && wr_data[2] == 8'hBF, "R3 ch3 field", wr_data[1], 8'hBE);
    chk(wr_data[3] == 8'h9E, "R5 R10 ch3 teardown no bias", wr_data[3], 8'h9E);
    chk(wr_cyc[2] - wr_cyc[0] >= GAP_C, "R4 gap with latency", wr_cyc[2] - wr_cyc[0], GAP_C);
    chk(hold_bad == 0, "R11 request held", hold_bad, 0);
  endtask

  task automatic t_ch2();
    mem[4] = 8'h03; mem[5] = 8'hFF;
    run(2'd2, 1, 4, -1, 0, 0);
    chk(got_sample == 10'h3FF, "R8 ch2 sample", got_sample, 10'h3FF);
    chk(n_wr == 5 && wr_data[0] == 8'hD8, "R5 bias write first", wr_data[0], 8'hD8);
    chk(wr_data[1] == 8'hF8, "R5 enable after bias", wr_data[1], 8'hF8);
    chk(wr_cyc[1] - wr_cyc[0] >= BIAS_C, "R5 bias lead", wr_cyc[1] - wr_cyc[0], BIAS_C);
    chk(wr_data[4] == 8'h9C, "R5 bias cleared", wr_data[4], 8'h9C);
  endtask

  task automatic t_timeout();
    run(2'd1, 0, -1, -1, 0, 0);
    chk(got_status == 2'b01, "R7 timeout status", got_status, 1);
    chk(n_rd == 1, "R7 no result read", n_rd, 1);
    chk(wr_cyc[3] - wr_cyc[2] >= TO_C, "R7 timeout length", wr_cyc[3] - wr_cyc[2], TO_C);
    chk(wr_data[3] == 8'h9A, "R10 timeout teardown", wr_data[3], 8'h9A);
  endtask

  task automatic t_stale();
    run(2'd1, 0, -1, -1, 1, 0);
    chk(got_status == 2'b01, "R6 stale irq ignored", got_status, 1);
    chk(n_rd == 1, "R6 no read on stale irq", n_rd, 1);
  endtask

  task automatic t_err_read();
    run(2'd0, 0, 2, 4, 0, 0);
    chk(got_status == 2'b10, "R9 read error status", got_status, 2);
    chk(n_wr == 4 && wr_data[3] == 8'h98, "R9 R10 teardown after error", wr_data[3], 8'h98);
  endtask

  task automatic t_err_first();
    run(2'd0, 0, 2, 0, 0, 0);
    chk(got_status == 2'b10, "R9 first access error", got_status, 2);
    chk(n_wr == 1 && wr_data[0][5] == 0 && wr_data[0][0] == 0, "R9 R10 only teardown", wr_data[0], 0);
  endtask

  task automatic t_busy();
    mem[0] = 8'h00; mem[1] = 8'h11;
    run(2'd0, 0, 3, -1, 0, 1);
    chk(wr_data[1][2:1] == 2'd0, "R1 channel unchanged by busy request", wr_data[1][2:1], 0);
    repeat (4) @(negedge clk);
    chk(busy_o == 0, "R1 busy request ignored", busy_o, 0);
    chk(n_rd == 3, "R1 no extra access", n_rd, 3);
    chk(got_sample == 10'h011, "R8 ch0 second pattern", got_sample, 10'h011);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = 8'h00;
    ctl_model = 8'h98;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_ch0();
    t_ch3_lat();
    t_ch2();
    t_timeout();
    t_stale();
    t_err_read();
    t_err_first();
    t_busy();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule